// File: doc/BRIEF.md
# Card Round Sequencer

This block plays out a single round of a simplified twenty-one card game. Two hand totals, one for the player and one for the dealer, are held in accumulators. Each accumulator is updated only by its own add strobe or by a shared clear. A sequencer does the following:

- It runs a fixed opening deal: two cards to the player, then one card to the dealer.
- It waits for the player to draw or stand.
- It lets the dealer draw until the dealer reaches the stand threshold.
- It settles the round as a win or a loss for the player.

Card values come from outside on `card_i`, from a random source or a test driver. The block consumes `card_i` on the clock edge at the end of a cycle where `card_req_o` is high. Player actions arrive as single-cycle pulses. Every decision is taken one cycle after the last card was added, so it always sees a settled total.

The round state is exported as a 3-bit code. Win and lose are decoded from that registered state. A separate `restart_i` pulse abandons the round in progress, clears both totals and starts a fresh deal. The asynchronous `rst_n` returns the block to its start state.

Top module: `card_round_seq`

## Requirements
- R1: While `rst_n` is low, `state_o` is 000, both totals are 0, and `card_req_o`, `win_o` and `lose_o` are 0.
- R2: The state code is 000 start, 001 first player card, 010 second player card, 011 dealer card then wait, 100 player drawing, 101 dealer drawing, 110 player wins, 111 player loses. From 000 the block passes through 001, 010 and 011 on its own, adding `card_i` to the player in 001 and 010 and to the dealer in 011. `win_o` is high exactly in 110 and `lose_o` exactly in 111.
- R3: A hand total increases by `card_i` (zero-extended) on the edge that ends a cycle where that hand is being dealt to. Otherwise it keeps its value unless cleared.
- R4: `card_req_o` is never high in two consecutive cycles, and each state step deals at most one card. Every dealt card is consumed exactly once, and the state decision comes in the cycle after the add.
- R5: While waiting in 011 or 100, a player total equal to 21 moves the block to 110.
- R6: While waiting in 011 or 100, a player total above 21 moves the block to 111.
- R7: While waiting in 011 or 100, a hit pulse moves to 100 and deals one player card, and a pass pulse moves to 101. With neither pulse, the state and both totals stay unchanged and no card is requested.
- R8: In 101 the dealer takes one card per step while its total is below 17. A dealer total above 21 moves to 110.
- R9: When the dealer total ends between 17 and 21, the round goes to 110 if the player total is strictly greater and to 111 otherwise, a tie included.
- R10: A `restart_i` pulse in any state clears both totals and enters 000 on the next edge, taking precedence over every other input and result.
- R11: In 110 and 111 the state holds and pass has no effect. A hit pulse returns the block to 000 with both totals cleared.
- R12: When inputs coincide while waiting, the 21 or bust result wins over hit, and hit wins over pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_i | input | 1 | Player draw request, one-cycle pulse |
| pass_i | input | 1 | Player stand request, one-cycle pulse |
| restart_i | input | 1 | Abandon round, clear totals, redeal; one-cycle pulse |
| card_i | input | CARD_W (4) | Value of the card on offer, 1 to 13 |
| state_o | output | 3 | Round state code |
| player_total_o | output | TOTAL_W (8) | Player hand total |
| dealer_total_o | output | TOTAL_W (8) | Dealer hand total |
| card_req_o | output | 1 | High in the cycle whose closing edge consumes `card_i` |
| win_o | output | 1 | Round settled as a player win |
| lose_o | output | 1 | Round settled as a player loss |

## Verification
The bench uses the default parameters: an 8-bit total, a 4-bit card, a target of 21 and a dealer threshold of 17. With card values up to 13, the player can bust on the opening two cards and can hit 21 exactly on the opening deal or on a draw. The dealer can land exactly on 17 or 21, and a tie at the stand point can be built directly. A reference model in the bench computes the outcome and final totals of each round from its card list and hit count, and the scoreboard compares them when the round settles.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;

  typedef enum logic [2:0] {
    ST_START  = 3'b000,
    ST_PCARD1 = 3'b001,
    ST_PCARD2 = 3'b010,
    ST_DCARD1 = 3'b011,
    ST_PDRAW  = 3'b100,
    ST_DDRAW  = 3'b101,
    ST_WIN    = 3'b110,
    ST_LOSE   = 3'b111
  } round_st_e;

endpackage

// File: rtl/crs_rst_sync.sv
`timescale 1ns/1ps
module crs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/crs_hand_accum.sv
`timescale 1ns/1ps
module crs_hand_accum #(
  parameter int TOTAL_W = 8,
  parameter int CARD_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               add_i,
  input  logic [CARD_W-1:0]  card_i,
  output logic [TOTAL_W-1:0] total_o
);

  localparam int PAD_W = TOTAL_W - CARD_W;

  logic [TOTAL_W-1:0] total_q;
  logic [TOTAL_W-1:0] total_d;
  logic               total_en;

  // clear wins over add; the enable covers both
  assign total_en = clr_i | add_i;

  always_comb begin
    if (clr_i) begin
      total_d = '0;
    end else begin
      total_d = total_q + {{PAD_W{1'b0}}, card_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
    end else if (total_en) begin
      total_q <= total_d;
    end
  end

  assign total_o = total_q;

endmodule

// File: rtl/crs_hand_eval.sv
`timescale 1ns/1ps
module crs_hand_eval #(
  parameter int TOTAL_W = 8,
  parameter int TARGET  = 21
) (
  input  logic [TOTAL_W-1:0] total_i,
  output logic               at_target_o,
  output logic               bust_o
);

  localparam logic [TOTAL_W-1:0] TGT = TOTAL_W'(TARGET);

  assign at_target_o = (total_i == TGT);
  assign bust_o      = (total_i >  TGT);

endmodule

// File: rtl/crs_round_ctrl.sv
`timescale 1ns/1ps
module crs_round_ctrl
  import crs_pkg::*;
#(
  parameter int TOTAL_W = 8,
  parameter int STAND   = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic               pass_i,
  input  logic               restart_i,
  input  logic [TOTAL_W-1:0] p_total_i,
  input  logic [TOTAL_W-1:0] d_total_i,
  input  logic               p_target_i,
  input  logic               p_bust_i,
  input  logic               d_target_i,
  input  logic               d_bust_i,
  output logic               add_p_o,
  output logic               add_d_o,
  output logic               clr_o,
  output logic [2:0]         state_o
);

  localparam logic [TOTAL_W-1:0] STAND_V = TOTAL_W'(STAND);

  round_st_e st_q, st_d;
  // settle_q low: this step deals its card; high: total has settled
  logic      settle_q, settle_d;
  logic      d_stands;

  assign d_stands = d_target_i | (d_total_i >= STAND_V);

  always_comb begin
    st_d     = st_q;
    settle_d = settle_q;
    add_p_o  = 1'b0;
    add_d_o  = 1'b0;
    clr_o    = 1'b0;
    if (restart_i) begin
      clr_o    = 1'b1;
      st_d     = ST_START;
      settle_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_START: begin
          st_d     = ST_PCARD1;
          settle_d = 1'b0;
        end
        ST_PCARD1, ST_PCARD2: begin
          if (!settle_q) begin
            add_p_o  = 1'b1;
            settle_d = 1'b1;
          end else begin
            st_d     = (st_q == ST_PCARD1) ? ST_PCARD2 : ST_DCARD1;
            settle_d = 1'b0;
          end
        end
        ST_DCARD1, ST_PDRAW: begin
          if (!settle_q) begin
            add_p_o  = (st_q == ST_PDRAW);
            add_d_o  = (st_q == ST_DCARD1);
            settle_d = 1'b1;
          end else if (p_target_i) begin
            st_d     = ST_WIN;
            settle_d = 1'b0;
          end else if (p_bust_i) begin
            st_d     = ST_LOSE;
            settle_d = 1'b0;
          end else if (hit_i) begin
            st_d     = ST_PDRAW;
            settle_d = 1'b0;
          end else if (pass_i) begin
            st_d     = ST_DDRAW;
            settle_d = 1'b0;
          end
        end
        ST_DDRAW: begin
          if (!settle_q) begin
            add_d_o  = 1'b1;
            settle_d = 1'b1;
          end else if (d_bust_i) begin
            st_d     = ST_WIN;
            settle_d = 1'b0;
          end else if (d_stands) begin
            st_d     = (p_total_i > d_total_i) ? ST_WIN : ST_LOSE;
            settle_d = 1'b0;
          end else begin
            settle_d = 1'b0;
          end
        end
        ST_WIN, ST_LOSE: begin
          if (hit_i) begin
            clr_o    = 1'b1;
            st_d     = ST_START;
            settle_d = 1'b0;
          end
        end
        default: begin
          st_d     = ST_START;
          settle_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_START;
      settle_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      settle_q <= settle_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/card_round_seq.sv
`timescale 1ns/1ps
module card_round_seq
  import crs_pkg::*;
#(
  parameter int TOTAL_W = 8,
  parameter int CARD_W  = 4,
  parameter int TARGET  = 21,
  parameter int STAND   = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic               pass_i,
  input  logic               restart_i,
  input  logic [CARD_W-1:0]  card_i,
  output logic [2:0]         state_o,
  output logic [TOTAL_W-1:0] player_total_o,
  output logic [TOTAL_W-1:0] dealer_total_o,
  output logic               card_req_o,
  output logic               win_o,
  output logic               lose_o
);

  localparam int NHANDS = 2;
  localparam int PL     = 0;
  localparam int DL     = 1;

  logic                rst_n_s;
  logic                clr;
  logic [NHANDS-1:0]   add_v;
  logic [NHANDS-1:0]   at_target;
  logic [NHANDS-1:0]   bust;
  logic [TOTAL_W-1:0]  total [NHANDS];

  crs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  for (genvar g = 0; g < NHANDS; g++) begin : g_hand
    crs_hand_accum #(
      .TOTAL_W (TOTAL_W),
      .CARD_W  (CARD_W)
    ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .clr_i   (clr),
      .add_i   (add_v[g]),
      .card_i  (card_i),
      .total_o (total[g])
    );

    crs_hand_eval #(
      .TOTAL_W (TOTAL_W),
      .TARGET  (TARGET)
    ) u_eval (
      .total_i     (total[g]),
      .at_target_o (at_target[g]),
      .bust_o      (bust[g])
    );
  end

  crs_round_ctrl #(
    .TOTAL_W (TOTAL_W),
    .STAND   (STAND)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .hit_i      (hit_i),
    .pass_i     (pass_i),
    .restart_i  (restart_i),
    .p_total_i  (total[PL]),
    .d_total_i  (total[DL]),
    .p_target_i (at_target[PL]),
    .p_bust_i   (bust[PL]),
    .d_target_i (at_target[DL]),
    .d_bust_i   (bust[DL]),
    .add_p_o    (add_v[PL]),
    .add_d_o    (add_v[DL]),
    .clr_o      (clr),
    .state_o    (state_o)
  );

  assign player_total_o = total[PL];
  assign dealer_total_o = total[DL];
  assign card_req_o     = |add_v;
  assign win_o          = (state_o == ST_WIN);
  assign lose_o         = (state_o == ST_LOSE);

endmodule

// File: rtl/card_round_seq_chk.sv
`timescale 1ns/1ps
module card_round_seq_chk
  import crs_pkg::*;
#(
  parameter int TOTAL_W = 8,
  parameter int CARD_W  = 4,
  parameter int TARGET  = 21,
  parameter int STAND   = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hit_i,
  input logic               pass_i,
  input logic               restart_i,
  input logic [CARD_W-1:0]  card_i,
  input logic [2:0]         state_o,
  input logic [TOTAL_W-1:0] player_total_o,
  input logic [TOTAL_W-1:0] dealer_total_o,
  input logic               card_req_o,
  input logic               win_o,
  input logic               lose_o
);

  localparam logic [TOTAL_W-1:0] TGT     = TOTAL_W'(TARGET);
  localparam logic [TOTAL_W-1:0] STAND_V = TOTAL_W'(STAND);

  logic [TOTAL_W-1:0] card_ext;
  logic               p_deal_st;
  logic               d_deal_st;
  logic               waiting_st;

  assign card_ext   = {{(TOTAL_W-CARD_W){1'b0}}, card_i};
  assign p_deal_st  = (state_o == ST_PCARD1) || (state_o == ST_PCARD2) || (state_o == ST_PDRAW);
  assign d_deal_st  = (state_o == ST_DCARD1) || (state_o == ST_DDRAW);
  assign waiting_st = (state_o == ST_DCARD1) || (state_o == ST_PDRAW);

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    card_req_o |=> !card_req_o);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_req_o && !restart_i && !win_o && !lose_o)
    |=> ($stable(player_total_o) && $stable(dealer_total_o)));

  p_padd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req_o && p_deal_st)
    |=> (player_total_o == $past(player_total_o) + $past(card_ext)) && $stable(dealer_total_o));

  p_dadd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_req_o && d_deal_st)
    |=> (dealer_total_o == $past(dealer_total_o) + $past(card_ext)) && $stable(player_total_o));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (state_o == ST_START) && (player_total_o == '0) && (dealer_total_o == '0));

  p_win_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) |-> (player_total_o == TGT) || (dealer_total_o > TGT)
                     || ((dealer_total_o >= STAND_V) && (player_total_o > dealer_total_o)));

  p_lose_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lose_o) |-> (player_total_o > TGT)
                      || ((dealer_total_o >= STAND_V) && (dealer_total_o <= TGT)
                          && (player_total_o <= dealer_total_o)));

  p_end_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_o || lose_o) && !hit_i && !restart_i) |=> $stable(state_o));

  // R7 and R12: hit beats pass when no result is pending
  p_hit_deal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_st && !card_req_o && hit_i && !restart_i && (player_total_o < TGT))
    |=> (state_o == ST_PDRAW) && card_req_o);

endmodule

bind card_round_seq card_round_seq_chk #(
  .TOTAL_W (TOTAL_W),
  .CARD_W  (CARD_W),
  .TARGET  (TARGET),
  .STAND   (STAND)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hit_i          (hit_i),
  .pass_i         (pass_i),
  .restart_i      (restart_i),
  .card_i         (card_i),
  .state_o        (state_o),
  .player_total_o (player_total_o),
  .dealer_total_o (dealer_total_o),
  .card_req_o     (card_req_o),
  .win_o          (win_o),
  .lose_o         (lose_o)
);

// File: tb/card_round_seq_tb.sv
`timescale 1ns/1ps
module card_round_seq_tb;

  localparam int TOTAL_W = 8;
  localparam int CARD_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_i = 1'b0;
  logic pass_i = 1'b0;
  logic restart_i = 1'b0;
  logic [CARD_W-1:0] card_r = 4'd1;
  logic [2:0] state_o;
  logic [TOTAL_W-1:0] player_total_o;
  logic [TOTAL_W-1:0] dealer_total_o;
  logic card_req_o;
  logic win_o;
  logic lose_o;

  card_round_seq u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .hit_i          (hit_i),
    .pass_i         (pass_i),
    .restart_i      (restart_i),
    .card_i         (card_r),
    .state_o        (state_o),
    .player_total_o (player_total_o),
    .dealer_total_o (dealer_total_o),
    .card_req_o     (card_req_o),
    .win_o          (win_o),
    .lose_o         (lose_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0] st;
    int         p;
    int         d;
    string      tag;
  } exp_t;

  int    checks = 0;
  int    errors = 0;
  int    deck[$];
  exp_t  exp_q[$];
  bit    req_seen = 1'b0;
  bit    done_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference outcome of a round from its cards and the number of hits
  function automatic void model(input int c[$], input int hits,
                                output logic [2:0] st, output int p, output int d);
    int i;
    int h;
    i = 3;
    h = hits;
    p = c[0] + c[1];
    d = c[2];
    st = 3'b000;
    forever begin
      if (p == 21) begin st = 3'b110; return; end
      if (p > 21)  begin st = 3'b111; return; end
      if (h == 0) break;
      p = p + c[i];
      i++;
      h--;
    end
    forever begin
      d = d + c[i];
      i++;
      if (d > 21) begin st = 3'b110; return; end
      if (d >= 17) begin st = (p > d) ? 3'b110 : 3'b111; return; end
    end
  endfunction

  // monitor: card supply and scoreboard at settle of each round
  always @(negedge clk) begin
    if (req_seen && deck.size() > 0) void'(deck.pop_front());
    req_seen = card_req_o;
    card_r = (deck.size() > 0) ? CARD_W'(deck[0]) : 4'd1;
    if ((win_o || lose_o) && !done_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected settle state", int'(state_o), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(state_o == e.st, "R9", {e.tag, " outcome"}, int'(state_o), int'(e.st));
        chk(int'(player_total_o) == e.p, "R3", {e.tag, " player total"}, int'(player_total_o), e.p);
        chk(int'(dealer_total_o) == e.d, "R8", {e.tag, " dealer total"}, int'(dealer_total_o), e.d);
      end
    end
    done_prev = win_o || lose_o;
  end

  task automatic wait_quiet();
    forever begin
      @(negedge clk);
      if (win_o || lose_o) break;
      if ((state_o == 3'b011 || state_o == 3'b100) && !card_req_o) break;
    end
  endtask

  task automatic play_round(input int c[$], input int hits, input string tag);
    exp_t e;
    int   left;
    bit   first;
    model(c, hits, e.st, e.p, e.d);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    deck = c;
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    left = hits;
    first = 1'b1;
    forever begin
      @(negedge clk);
      if (win_o || lose_o) break;
      if ((state_o == 3'b011 || state_o == 3'b100) && !card_req_o) begin
        if (first && state_o == 3'b011) begin
          // R2 opening deal: two player cards, one dealer card
          chk(int'(player_total_o) == c[0] + c[1], "R2", {tag, " opening player"}, int'(player_total_o), c[0] + c[1]);
          chk(int'(dealer_total_o) == c[2], "R2", {tag, " opening dealer"}, int'(dealer_total_o), c[2]);
          first = 1'b0;
        end
        if (left > 0) begin
          hit_i = 1'b1;
          left--;
        end else begin
          pass_i = 1'b1;
        end
        @(negedge clk);
        hit_i = 1'b0;
        pass_i = 1'b0;
      end
    end
    chk(deck.size() == 0, "R4", {tag, " cards left unused"}, deck.size(), 0);
  endtask

  initial begin
    int p0;
    int d0;
    bit saw_req;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(state_o == 3'b000, "R1", "reset state", int'(state_o), 0);
    chk(player_total_o == 0 && dealer_total_o == 0, "R1", "reset totals", int'(player_total_o) + int'(dealer_total_o), 0);
    chk(!card_req_o && !win_o && !lose_o, "R1", "reset strobes", int'({card_req_o, win_o, lose_o}), 0);
    rst_n = 1'b1;

    // opening deal with default card 1, then idle wait: nothing moves (R7)
    wait_quiet();
    chk(state_o == 3'b011, "R2", "wait after opening", int'(state_o), 3);
    chk(player_total_o == 2 && dealer_total_o == 1, "R2", "opening totals p*16+d", int'(player_total_o) * 16 + int'(dealer_total_o), 2 * 16 + 1);
    p0 = player_total_o;
    d0 = dealer_total_o;
    saw_req = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (card_req_o) saw_req = 1'b1;
    end
    chk(state_o == 3'b011 && !saw_req, "R7", "idle wait holds", int'(state_o), 3);
    chk(int'(player_total_o) == p0 && int'(dealer_total_o) == d0, "R7", "idle totals", int'(player_total_o), p0);

    // R12: hit and pass together -> draw; R4 one-cycle strobe then add
    hit_i = 1'b1;
    pass_i = 1'b1;
    @(negedge clk);
    hit_i = 1'b0;
    pass_i = 1'b0;
    chk(state_o == 3'b100 && card_req_o, "R12", "hit over pass", int'(state_o), 4);
    @(negedge clk);
    chk(!card_req_o, "R4", "strobe one cycle", int'(card_req_o), 0);
    chk(int'(player_total_o) == p0 + 1, "R3", "player add one card", int'(player_total_o), p0 + 1);
    chk(int'(dealer_total_o) == d0, "R3", "dealer unchanged", int'(dealer_total_o), d0);

    // R10: restart with hit in the same cycle
    restart_i = 1'b1;
    hit_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    hit_i = 1'b0;
    chk(state_o == 3'b000, "R10", "restart state", int'(state_o), 0);
    chk(player_total_o == 0 && dealer_total_o == 0, "R10", "restart totals", int'(player_total_o) + int'(dealer_total_o), 0);
    wait_quiet();

    // R5 opening 21, hit pressed at the same time (R12)
    play_round('{10, 11, 5}, 1, "R5 opening 21");
    // R11: pass ignored in the win state, hit returns to start
    pass_i = 1'b1;
    @(negedge clk);
    pass_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(state_o == 3'b110, "R11", "pass ignored at win", int'(state_o), 6);
    chk(player_total_o == 21 && dealer_total_o == 5, "R11", "totals held at win", int'(player_total_o), 21);
    hit_i = 1'b1;
    @(negedge clk);
    hit_i = 1'b0;
    chk(state_o == 3'b000, "R11", "hit returns to start", int'(state_o), 0);
    chk(player_total_o == 0 && dealer_total_o == 0, "R11", "totals cleared on return", int'(player_total_o) + int'(dealer_total_o), 0);
    wait_quiet();

    play_round('{13, 13, 4}, 0, "R6 opening bust");
    play_round('{5, 6, 4, 10}, 1, "R5 draw to 21");
    play_round('{10, 5, 3, 9}, 1, "R6 draw bust");
    play_round('{10, 8, 9, 5, 10}, 0, "R8 dealer bust");
    play_round('{10, 7, 10, 8}, 0, "R9 dealer higher");
    play_round('{10, 8, 10, 8}, 0, "R9 tie loses");
    play_round('{10, 9, 10, 7}, 0, "R9 player higher");
    play_round('{10, 9, 8, 13}, 0, "R9 dealer 21");
    play_round('{2, 3, 4, 5, 6, 10, 3}, 2, "R8 two draws each");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "rounds not settled", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule